// File: doc/BRIEF.md
# Indexed Configuration Register Port

This block is the configuration front end of a system controller. Host software reaches a window of byte-wide configuration registers through two I/O addresses. A write to the index port selects a register, and the next access to the data port reads or writes it. The window starts at a base index taken from straps. A variant strap selects its length: 119 registers for the extended variant and 18 for the basic one. Every data-port access, accepted or not, drops the selected index back to zero. Software must therefore write the index again before each data access.

The register contents go out as one flat vector to the downstream decode logic, with register r in bits r*8+7 down to r*8. After each accepted write, the block emits a one-cycle strobe. The strobe carries the relative register number and a mask of the bits that changed. Relative register 0x19 is a status register. Hardware sets its bits through a set input, and software clears them by writing ones. Two independent scratch bytes sit at their own addresses. In the extended variant, one index outside the window passes a byte from an external port through to the host.

The index tracker is a two-state machine. ST_CLEAR means no index is held and the index is zero. ST_ARMED means an index has been latched. Three transitions are named. LATCH goes from ST_CLEAR to ST_ARMED on an index-port write. RELATCH goes from ST_ARMED to ST_ARMED on a further index-port write. CONSUME goes from ST_ARMED to ST_CLEAR on any data-port read or write. A data access in ST_CLEAR stays in ST_CLEAR.

Top module: `cfg_index_port`

## Requirements
- R1: A synchronous active-high reset clears the index to 0x00 and sets both scratch bytes to 0xFF. In the extended variant it loads relative registers 0x09=0x40, 0x11=0x09, 0x12=0xFF, 0x1F=0x20, 0x23=0xF0 and 0x26=0x01. In the basic variant it loads relative register 0x11=0x01. Every other register resets to 0x00.
- R2: A write at address 0x0022 latches the 8-bit index. A read at 0x0022 returns 0xFF.
- R3: A data-port access at 0x0023 is accepted only when base <= index <= base+count-1, where count is 0x77 with `strap_ext`=1 and 0x12 with `strap_ext`=0. The register used is index minus base.
- R4: After any read or write at 0x0023, whether in the window or not, the index is 0x00. A following data access without a new index write therefore targets index 0x00.
- R5: A data-port read outside the window returns 0xFF unless R7 applies. A data-port write outside the window changes no register and raises no strobe.
- R6: Relative register 0x19 is write-one-to-clear. A written 1 clears that bit and a written 0 leaves it. Bits of `stat_set` set it in any cycle, and a set wins over a clear in the same cycle. All other registers take the written byte.
- R7: With `strap_ext`=1, a data-port read at index 0x1C returns `ext_port_val` when 0x1C lies outside the window. Inside the window the register wins. With `strap_ext`=0 the read returns 0xFF.
- R8: Scratch bytes at 0x00E1 and 0x00E2 are independent read/write storage.
- R9: In the cycle after an accepted data-port write, `wr_strobe` is 1 for one cycle. `wr_reg` then holds the relative register, and `wr_xor` holds old XOR new value of that register.
- R10: `cfg_regs` always presents every register's current value, with register r at bits [r*8+7:r*8].
- R11: Reads at any other address return 0xFF, and writes there change nothing. `io_rdata` is 0xFF when `io_rd` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| strap_ext | input | 1 | Variant strap: 1 extended (119 registers), 0 basic (18) |
| base_idx | input | 8 | Strapped window base index |
| io_addr | input | 16 | I/O address |
| io_wr | input | 1 | I/O write strobe |
| io_rd | input | 1 | I/O read strobe |
| io_wdata | input | 8 | I/O write data |
| io_rdata | output | 8 | I/O read data, valid in the cycle `io_rd` is high |
| ext_port_val | input | 8 | Byte passed through at index 0x1C (extended variant) |
| stat_set | input | 8 | Hardware set bits for status register 0x19 |
| cfg_regs | output | 952 | Flat register contents |
| wr_strobe | output | 1 | One-cycle pulse after an accepted write |
| wr_reg | output | 7 | Relative register of the last accepted write |
| wr_xor | output | 8 | Bits changed by the last accepted write |

## Verification
Suppose the index tracker stays in ST_ARMED after a data access. The very next index-less data read then returns a windowed register instead of 0xFF, or register 0, in that same cycle. A wrong window bound or a wrong base subtraction shows on the first read at the edge index, either as a value where 0xFF was due or the reverse. A corrupted register, including a status bit that a written zero cleared, appears on `cfg_regs` one clock after the write and is caught at the next comparison. A wrong change mask appears on `wr_xor` during the strobe cycle.

// File: rtl/cfg_port_pkg.sv
package cfg_port_pkg;

    typedef logic [7:0] byte_t;

    typedef enum logic {
        ST_CLEAR = 1'b0,
        ST_ARMED = 1'b1
    } idx_state_e;

    // Strap-dependent power-on value of a relative register.
    function automatic byte_t strap_default(input int unsigned r, input logic ext);
        byte_t v;
        v = 8'h00;
        if (ext) begin
            case (r)
                32'h09:  v = 8'h40;
                32'h11:  v = 8'h09;
                32'h12:  v = 8'hFF;
                32'h1F:  v = 8'h20;
                32'h23:  v = 8'hF0;
                32'h26:  v = 8'h01;
                default: v = 8'h00;
            endcase
        end else if (r == 32'h11) begin
            v = 8'h01;
        end
        return v;
    endfunction

endpackage

// File: rtl/cfg_index_fsm.sv
module cfg_index_fsm
    import cfg_port_pkg::*;
#(
    parameter int unsigned           ADDR_W     = 16,
    parameter logic [ADDR_W-1:0]     INDEX_PORT = 16'h0022,
    parameter logic [ADDR_W-1:0]     DATA_PORT  = 16'h0023
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] io_addr,
    input  logic              io_wr,
    input  logic              io_rd,
    input  byte_t             io_wdata,
    output byte_t             cur_idx,
    output logic              data_acc
);

    idx_state_e state_q, state_d;
    byte_t      idx_q, idx_d;
    logic       idx_wr;

    always_comb begin
        idx_wr   = io_wr && (io_addr == INDEX_PORT);
        data_acc = (io_wr || io_rd) && (io_addr == DATA_PORT);
    end

    // Next-state logic: LATCH, RELATCH, CONSUME
    always_comb begin
        state_d = state_q;
        idx_d   = idx_q;
        unique case (state_q)
            ST_CLEAR: begin
                if (idx_wr) begin
                    state_d = ST_ARMED;
                    idx_d   = io_wdata;
                end
            end
            ST_ARMED: begin
                if (idx_wr) begin
                    state_d = ST_ARMED;
                    idx_d   = io_wdata;
                end else if (data_acc) begin
                    state_d = ST_CLEAR;
                    idx_d   = 8'h00;
                end
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_CLEAR;
            idx_q   <= 8'h00;
        end else begin
            state_q <= state_d;
            idx_q   <= idx_d;
        end
    end

    always_comb begin
        cur_idx = (state_q == ST_ARMED) ? idx_q : 8'h00;
    end

    assert_idx_consume_R4: assert property (@(posedge clk) disable iff (rst)
        data_acc |=> (cur_idx == 8'h00));

    assert_idx_latch_R2: assert property (@(posedge clk) disable iff (rst)
        idx_wr |=> (cur_idx == $past(io_wdata)));

endmodule

// File: rtl/cfg_window_decode.sv
module cfg_window_decode
    import cfg_port_pkg::*;
#(
    parameter int unsigned REL_W       = 7,
    parameter int unsigned EXT_COUNT   = 119,
    parameter int unsigned BASIC_COUNT = 18,
    parameter byte_t       EXT_IDX     = 8'h1C
) (
    input  byte_t             cur_idx,
    input  byte_t             base_idx,
    input  logic              strap_ext,
    output logic              in_win,
    output logic [REL_W-1:0]  rel,
    output logic              ext_hit
);

    logic [8:0] count;
    logic [8:0] last;

    always_comb begin
        count   = strap_ext ? 9'(EXT_COUNT) : 9'(BASIC_COUNT);
        last    = {1'b0, base_idx} + count - 9'd1;
        in_win  = (cur_idx >= base_idx) && ({1'b0, cur_idx} <= last);
        rel     = REL_W'(cur_idx - base_idx);
        ext_hit = strap_ext && (cur_idx == EXT_IDX);
    end

endmodule

// File: rtl/cfg_reg_bank.sv
module cfg_reg_bank
    import cfg_port_pkg::*;
#(
    parameter int unsigned REG_MAX = 119,
    parameter int unsigned REL_W   = 7,
    parameter int unsigned W1C_REL = 25
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 strap_ext,
    input  logic                 wr_en,
    input  logic [REL_W-1:0]     rel,
    input  byte_t                wdata,
    input  byte_t                stat_set,
    output logic [REG_MAX*8-1:0] regs_flat,
    output byte_t                rd_byte,
    output logic                 stb,
    output logic [REL_W-1:0]     stb_reg,
    output byte_t                stb_xor
);

    byte_t mem [REG_MAX];
    byte_t nxt_val;

    always_comb begin
        rd_byte = (32'(rel) < REG_MAX) ? mem[rel] : 8'hFF;
        nxt_val = (32'(rel) == W1C_REL) ? ((rd_byte & ~wdata) | stat_set) : wdata;
    end

    for (genvar g = 0; g < REG_MAX; g++) begin : g_reg
        if (g == W1C_REL) begin : g_w1c
            always_ff @(posedge clk) begin
                if (rst)
                    mem[g] <= strap_default(g, strap_ext);
                else if (wr_en && (rel == REL_W'(g)))
                    mem[g] <= (mem[g] & ~wdata) | stat_set;
                else
                    mem[g] <= mem[g] | stat_set;
            end

            assert_w1c_no_raise_R6: assert property (@(posedge clk) disable iff (rst)
                !rst |=> ((mem[g] & ~$past(mem[g]) & ~$past(stat_set)) == 8'h00));
        end else begin : g_plain
            always_ff @(posedge clk) begin
                if (rst)
                    mem[g] <= strap_default(g, strap_ext);
                else if (wr_en && (rel == REL_W'(g)))
                    mem[g] <= wdata;
            end
        end
        assign regs_flat[g*8 +: 8] = mem[g];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            stb     <= 1'b0;
            stb_reg <= '0;
            stb_xor <= 8'h00;
        end else begin
            stb <= wr_en;
            if (wr_en) begin
                stb_reg <= rel;
                stb_xor <= rd_byte ^ nxt_val;
            end
        end
    end

    assert_strobe_cause_R9: assert property (@(posedge clk) disable iff (rst)
        stb |-> ($past(wr_en) && (stb_reg == $past(rel))));

    assert_hold_without_write_R5: assert property (@(posedge clk) disable iff (rst)
        (!wr_en && (stat_set == 8'h00)) |=> $stable(regs_flat));

endmodule

// File: rtl/cfg_index_port.sv
module cfg_index_port
    import cfg_port_pkg::*;
#(
    parameter int unsigned       ADDR_W       = 16,
    parameter int unsigned       REG_MAX      = 119,
    parameter int unsigned       BASIC_COUNT  = 18,
    parameter logic [ADDR_W-1:0] INDEX_PORT   = 16'h0022,
    parameter logic [ADDR_W-1:0] DATA_PORT    = 16'h0023,
    parameter int unsigned       SCRATCH_BASE = 32'h00E1,
    parameter int unsigned       SCRATCH_N    = 2,
    parameter byte_t             EXT_IDX      = 8'h1C,
    parameter int unsigned       W1C_REL      = 25,
    localparam int unsigned      REL_W        = $clog2(REG_MAX)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 strap_ext,
    input  logic [7:0]           base_idx,
    input  logic [ADDR_W-1:0]    io_addr,
    input  logic                 io_wr,
    input  logic                 io_rd,
    input  logic [7:0]           io_wdata,
    output logic [7:0]           io_rdata,
    input  logic [7:0]           ext_port_val,
    input  logic [7:0]           stat_set,
    output logic [REG_MAX*8-1:0] cfg_regs,
    output logic                 wr_strobe,
    output logic [REL_W-1:0]     wr_reg,
    output logic [7:0]           wr_xor
);

    byte_t            cur_idx;
    logic             data_acc;
    logic             in_win;
    logic             ext_hit;
    logic [REL_W-1:0] rel;
    byte_t            rd_byte;
    logic             reg_wr;
    logic             data_rd;
    logic [SCRATCH_N-1:0] scr_hit;
    byte_t            scr [SCRATCH_N];

    cfg_index_fsm #(
        .ADDR_W     (ADDR_W),
        .INDEX_PORT (INDEX_PORT),
        .DATA_PORT  (DATA_PORT)
    ) u_fsm (
        .clk      (clk),
        .rst      (rst),
        .io_addr  (io_addr),
        .io_wr    (io_wr),
        .io_rd    (io_rd),
        .io_wdata (io_wdata),
        .cur_idx  (cur_idx),
        .data_acc (data_acc)
    );

    cfg_window_decode #(
        .REL_W       (REL_W),
        .EXT_COUNT   (REG_MAX),
        .BASIC_COUNT (BASIC_COUNT),
        .EXT_IDX     (EXT_IDX)
    ) u_dec (
        .cur_idx   (cur_idx),
        .base_idx  (base_idx),
        .strap_ext (strap_ext),
        .in_win    (in_win),
        .rel       (rel),
        .ext_hit   (ext_hit)
    );

    always_comb begin
        reg_wr  = data_acc && io_wr && in_win;
        data_rd = io_rd && (io_addr == DATA_PORT);
    end

    cfg_reg_bank #(
        .REG_MAX (REG_MAX),
        .REL_W   (REL_W),
        .W1C_REL (W1C_REL)
    ) u_bank (
        .clk       (clk),
        .rst       (rst),
        .strap_ext (strap_ext),
        .wr_en     (reg_wr),
        .rel       (rel),
        .wdata     (io_wdata),
        .stat_set  (stat_set),
        .regs_flat (cfg_regs),
        .rd_byte   (rd_byte),
        .stb       (wr_strobe),
        .stb_reg   (wr_reg),
        .stb_xor   (wr_xor)
    );

    for (genvar g = 0; g < SCRATCH_N; g++) begin : g_scr
        assign scr_hit[g] = (io_addr == ADDR_W'(SCRATCH_BASE + g));
        always_ff @(posedge clk) begin
            if (rst)
                scr[g] <= 8'hFF;
            else if (io_wr && scr_hit[g])
                scr[g] <= io_wdata;
        end

        assert_scratch_hold_R8: assert property (@(posedge clk) disable iff (rst)
            !(io_wr && scr_hit[g]) |=> $stable(scr[g]));
    end

    always_comb begin
        io_rdata = 8'hFF;
        if (data_rd) begin
            if (in_win)
                io_rdata = rd_byte;
            else if (ext_hit)
                io_rdata = ext_port_val;
        end else if (io_rd) begin
            for (int k = 0; k < SCRATCH_N; k++)
                if (scr_hit[k]) io_rdata = scr[k];
        end
    end

    assert_oow_float_R5: assert property (@(posedge clk) disable iff (rst)
        (data_rd && !in_win && !ext_hit) |-> (io_rdata == 8'hFF));

    assert_ext_pass_R7: assert property (@(posedge clk) disable iff (rst)
        (data_rd && !in_win && ext_hit) |-> (io_rdata == ext_port_val));

    assert_strobe_only_accepted_R3: assert property (@(posedge clk) disable iff (rst)
        (data_acc && io_wr && !in_win) |=> !wr_strobe);

endmodule

// File: tb/cfg_index_port_bench.sv
module cfg_index_port_bench;

    localparam int REG_MAX = 119;

    logic                 clk = 1'b0;
    logic                 rst = 1'b1;
    logic                 strap_ext = 1'b1;
    logic [7:0]           base_idx = 8'h50;
    logic [15:0]          io_addr = '0;
    logic                 io_wr = 1'b0;
    logic                 io_rd = 1'b0;
    logic [7:0]           io_wdata = '0;
    logic [7:0]           io_rdata;
    logic [7:0]           ext_port_val = 8'h3C;
    logic [7:0]           stat_set = '0;
    logic [REG_MAX*8-1:0] cfg_regs;
    logic                 wr_strobe;
    logic [6:0]           wr_reg;
    logic [7:0]           wr_xor;

    always #10 clk = ~clk;

    cfg_index_port u_cfg_index_port (
        .clk(clk), .rst(rst), .strap_ext(strap_ext), .base_idx(base_idx),
        .io_addr(io_addr), .io_wr(io_wr), .io_rd(io_rd), .io_wdata(io_wdata),
        .io_rdata(io_rdata), .ext_port_val(ext_port_val), .stat_set(stat_set),
        .cfg_regs(cfg_regs), .wr_strobe(wr_strobe), .wr_reg(wr_reg), .wr_xor(wr_xor)
    );

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    // behavioural model
    int m_reg [REG_MAX];
    int m_idx;
    int m_scr [2];
    bit m_ext;
    int m_base;
    bit e_stb;
    int e_reg, e_xor;
    bit m_live;

    function automatic int dflt(int r, bit ext);
        if (ext) begin
            if (r == 'h09) return 'h40;
            if (r == 'h11) return 'h09;
            if (r == 'h12) return 'hFF;
            if (r == 'h1F) return 'h20;
            if (r == 'h23) return 'hF0;
            if (r == 'h26) return 'h01;
            return 0;
        end
        return (r == 'h11) ? 'h01 : 0;
    endfunction

    function automatic bit inwin();
        int cnt = m_ext ? 'h77 : 'h12;
        return (m_idx >= m_base) && (m_idx <= m_base + cnt - 1);
    endfunction

    function automatic int mdl_read(int a);
        if (a == 'h23) begin
            if (inwin()) return m_reg[m_idx - m_base];
            if (m_ext && m_idx == 'h1C) return int'(ext_port_val);
            return 'hFF;
        end
        if (a == 'hE1) return m_scr[0];
        if (a == 'hE2) return m_scr[1];
        return 'hFF;
    endfunction

    task automatic check(string tag, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic compare_state();
        int bad = 0;
        int act, exp;
        if (!m_live) return;
        for (int r = 0; r < REG_MAX; r++)
            if (int'(cfg_regs[r*8 +: 8]) != m_reg[r]) bad++;
        check("R10 register contents mismatch count", bad, 0);
        act = wr_strobe ? ((1 << 16) | (int'(wr_reg) << 8) | int'(wr_xor)) : 0;
        exp = e_stb ? ((1 << 16) | (e_reg << 8) | e_xor) : 0;
        check("R9 strobe/reg/xor", act, exp);
    endtask

    task automatic mdl_step(int a, bit w, bit r, int d, int s);
        bit hit19 = 0;
        e_stb = 0;
        if (a == 'h22 && w) m_idx = d;
        else if (a == 'h23 && (w || r)) begin
            if (w && inwin()) begin
                int rl = m_idx - m_base;
                int old = m_reg[rl];
                int nw = (rl == 'h19) ? ((old & ~d & 'hFF) | s) : d;
                m_reg[rl] = nw;
                e_stb = 1; e_reg = rl; e_xor = old ^ nw;
                hit19 = (rl == 'h19);
            end
            m_idx = 0;
        end else if (a == 'hE1 && w) m_scr[0] = d;
        else if (a == 'hE2 && w) m_scr[1] = d;
        if (!hit19) m_reg['h19] = m_reg['h19] | s;
    endtask

    task automatic cyc(int a, bit w, bit r, int d, int s, string tag);
        @(negedge clk);
        compare_state();
        io_addr = 16'(a); io_wr = w; io_rd = r; io_wdata = 8'(d); stat_set = 8'(s);
        #2;
        if (r) check(tag, int'(io_rdata), mdl_read(a));
        mdl_step(a, w, r, d, s);
    endtask

    task automatic wr(int a, int d, string tag); cyc(a, 1, 0, d, 0, tag); endtask
    task automatic rd(int a, string tag);        cyc(a, 0, 1, 0, 0, tag); endtask
    task automatic idle();                        cyc(0, 0, 0, 0, 0, "idle"); endtask

    task automatic do_reset(bit ext, int base);
        @(negedge clk);
        m_live = 0;
        rst = 1; strap_ext = ext; base_idx = 8'(base);
        io_wr = 0; io_rd = 0; io_addr = '0; stat_set = '0;
        @(negedge clk);
        @(negedge clk);
        rst = 0;
        m_ext = ext; m_base = base; m_idx = 0; e_stb = 0;
        for (int r = 0; r < REG_MAX; r++) m_reg[r] = dflt(r, ext);
        m_scr[0] = 'hFF; m_scr[1] = 'hFF;
        m_live = 1;
    endtask

    task automatic report();
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired actual=hung expected=done");
        report();
        $finish;
    end

    initial begin
        // Phase A: extended variant, base 0x50
        do_reset(1, 'h50);
        @(negedge clk);
        check("R1 reset default 0x09", int'(cfg_regs['h09*8 +: 8]), 'h40);
        check("R1 reset default 0x12", int'(cfg_regs['h12*8 +: 8]), 'hFF);
        check("R1 reset no strobe", int'(wr_strobe), 0);
        wr('h22, 'h59, "R2"); rd('h23, "R1 read default via port");
        rd('hE1, "R1 scratch reset"); rd('hE2, "R1 scratch reset");
        wr('h22, 'h52, "R2"); wr('h23, 'hA5, "R3");
        rd('h22, "R2 index port read floats");
        wr('h22, 'h52, "R2"); rd('h23, "R3 read back");
        wr('h22, 'hC6, "R3"); wr('h23, 'h5E, "R3 last index write");
        wr('h22, 'hC6, "R3"); rd('h23, "R3 last index read");
        wr('h22, 'hC7, "R5"); wr('h23, 'h33, "R5 write above window");
        wr('h22, 'hC7, "R5"); rd('h23, "R5 read above window");
        wr('h22, 'h4F, "R5"); rd('h23, "R5 read below window");
        wr('h22, 'h55, "R4"); wr('h23, 'h66, "R4");
        wr('h23, 'h77, "R4 write after consume ignored");
        rd('h23, "R4 read after consume");
        cyc(0, 0, 0, 0, 'h0F, "R6 hardware set");
        wr('h22, 'h69, "R6"); rd('h23, "R6 status set");
        wr('h22, 'h69, "R6"); wr('h23, 'h05, "R6 clear ones");
        wr('h22, 'h69, "R6"); wr('h23, 'h00, "R6 zero write");
        wr('h22, 'h69, "R6"); rd('h23, "R6 after clears");
        wr('h22, 'h69, "R6"); cyc('h23, 1, 0, 'h02, 'h02, "R6 set wins");
        wr('h22, 'h69, "R6"); rd('h23, "R6 set wins readback");
        wr('h22, 'h1C, "R7"); rd('h23, "R7 external byte");
        ext_port_val = 8'hC3;
        wr('h22, 'h1C, "R7"); rd('h23, "R7 external byte changed");
        wr('hE1, 'h12, "R8"); wr('hE2, 'h34, "R8");
        rd('hE1, "R8 scratch 0"); rd('hE2, "R8 scratch 1");
        wr('h21, 'h99, "R11"); rd('h24, "R11 unmapped read");
        cyc('h23, 0, 0, 0, 0, "R11");
        @(negedge clk); #2;
        check("R11 rdata idle", int'(io_rdata), 'hFF);
        idle();

        // Phase B: basic variant, base 0x60
        do_reset(0, 'h60);
        wr('h22, 'h71, "R1"); rd('h23, "R1 basic default");
        wr('h22, 'h71, "R3"); wr('h23, 'hE7, "R3 basic last");
        wr('h22, 'h72, "R3"); wr('h23, 'h11, "R3 basic beyond");
        wr('h22, 'h72, "R5"); rd('h23, "R5 basic beyond");
        wr('h22, 'h1C, "R7"); rd('h23, "R7 basic floats");
        idle();

        // Phase C: extended variant, base 0x00
        do_reset(1, 'h00);
        wr('h22, 'h00, "R4"); wr('h23, 'h11, "R4");
        wr('h22, 'h05, "R4"); rd('h23, "R4 reg5");
        rd('h23, "R4 index-less targets index 0");
        wr('h22, 'h1C, "R7"); wr('h23, 'h5A, "R7");
        wr('h22, 'h1C, "R7"); rd('h23, "R7 window wins");
        idle(); idle();

        report();
        $finish;
    end

endmodule